// File: doc/BRIEF.md
# Prescaled Interval Timer with Live Count Capture

This block is a 16-bit interval timer for a microcontroller-class subsystem. A divider on the system clock produces periodic enable ticks at one of three rates. A slow-clock tick input can stand in for the slowest rate. The running count advances by one on each selected tick. When the count equals the programmed period, the block raises a one-clock interrupt pulse and restarts from zero. Software sets this up through a small register port: a control word and a period word, both write-only.

Software cannot read the count directly. Instead, a capture-enable bit makes the block copy the count into a capture register on every tick. The capture register sits on an output port and always shows a live, coherent count value. After capture is enabled, the first valid value appears only after the next source tick. Until then the register keeps its older contents.

Top module: `ptmr_top`

## Requirements
- R1: After reset the timer is stopped, `irq` is 0 and `capture` is 0.
- R2: While the run bit (control bit 0) is 0, the count and the divider are held at 0. Setting the bit starts counting from 0. The first tick comes 2^N clocks after the edge that loads the control word.
- R3: The source-select field is control bits 2:1. When the divider-select bit (control bit 4) is 0 and `slow_mode` is 0, code 2 ticks every 8 clocks, code 1 every 128 clocks and code 0 every 2048 clocks.
- R4: With source code 0, if the divider-select bit is 1 or `slow_mode` is 1, the tick comes on every eighth `slow_tick` pulse counted since start.
- R5: Source code 3 produces no ticks: the count, `capture` and `irq` stay unchanged.
- R6: On a tick where count equals period, the count becomes 0 and `irq` is 1 for exactly the following clock. On any other tick the count increments by 1. The interrupt therefore repeats every period+1 ticks.
- R7: A period of 0 gives an interrupt on every tick.
- R8: A period write (address 1) takes part in the compare from the next tick onward, even while the timer runs.
- R9: When the capture-enable bit (control bit 3) is 1, each tick loads `capture` with the count as it stands after that tick.
- R10: `capture` does not change while capture is disabled, while the timer is stopped, while the source is code 3, or between enabling and the first tick.
- R11: The register port decodes address 0 as control and address 1 as period. A write takes effect on the clock edge where `reg_wr` is sampled high. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 period |
| reg_wdata | input | 16 | Write data |
| slow_tick | input | 1 | One-clock pulse per low-speed clock period |
| slow_mode | input | 1 | Low-speed clock mode; moves code 0 onto the slow tick |
| capture | output | 16 | Captured count |
| irq | output | 1 | Period-match interrupt pulse |

## Verification
A register write is sampled on a rising edge and acts from that edge onward. After that, the divider advances once per clock, or once per slow pulse. The count, `capture` and `irq` all change on the same edge that ends the 2^N-th divider step, so every result is due the clock after its tick is decoded. The bench keeps a cycle-stepped arithmetic model that applies the same ordering: compare against the period held before the edge, then apply the write. It samples `irq` and `capture` 1 ns after every rising edge and compares them with the model, so a result that comes one clock early or late is reported in that very cycle.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
// ptmr_pkg: shared control-word layout and register addresses for the timer.
// Assumes control fields occupy the low five bits of the write data.
package ptmr_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_MID  = 2'b01,
        SRC_FAST = 2'b10,
        SRC_NONE = 2'b11
    } src_e;

    typedef struct packed {
        logic divsel;   // bit 4
        logic cap_en;   // bit 3
        src_e src;      // bits 2:1
        logic run;      // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;

endpackage

// File: rtl/ptmr_regs.sv
`timescale 1ns/1ps
// ptmr_regs: write-only control and period registers.
// Assumes DATA_W >= control width; unused addresses are ignored.
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] period
);

    // Load the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            period <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL)
                ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            else if (reg_addr == ADDR_PERIOD)
                period <= reg_wdata;
        end
    end

    // R11
    bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr > ADDR_PERIOD) |=> ($stable(ctrl) && $stable(period)));

endmodule

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
// ptmr_prescaler: free-running binary divider plus slow-tick divider.
// Both are cleared while stopped so the first tick after start is at a fixed
// distance. tap[k] is a one-clock pulse every 2^(k+1) clocks.
module ptmr_prescaler #(
    parameter int DIV_W = 11,
    parameter int LS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow_tick,
    output logic [DIV_W-1:0] tap,
    output logic             slow_tap
);

    logic [DIV_W-1:0] div_cnt;
    logic [LS_W-1:0]  ls_cnt;

    // Advance the system-clock divider while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // Count slow-clock pulses while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            ls_cnt <= '0;
        else if (slow_tick)
            ls_cnt <= ls_cnt + 1'b1;
    end

    // One tap per divider stage: pulses when all lower bits are set.
    for (genvar k = 0; k < DIV_W; k++) begin : g_tap
        assign tap[k] = run && (&div_cnt[k:0]);
    end

    assign slow_tap = run && slow_tick && (&ls_cnt);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_cnt == '0 && ls_cnt == '0));

endmodule

// File: rtl/ptmr_tick_sel.sv
`timescale 1ns/1ps
// ptmr_tick_sel: maps the source code, divider select and slow mode onto one
// prescaler tap. Assumes every tap index is within DIV_W.
module ptmr_tick_sel
    import ptmr_pkg::*;
#(
    parameter int DIV_W     = 11,
    parameter int TAP_SLOW  = 11,
    parameter int TAP_MID   = 7,
    parameter int TAP_FAST  = 3
) (
    input  logic [DIV_W-1:0] tap,
    input  logic             slow_tap,
    input  src_e             src,
    input  logic             divsel,
    input  logic             slow_mode,
    output logic             tick
);

    logic use_slow;
    assign use_slow = divsel || slow_mode;

    // Select the active source tick.
    always_comb begin
        case (src)
            SRC_SLOW: tick = use_slow ? slow_tap : tap[TAP_SLOW-1];
            SRC_MID:  tick = tap[TAP_MID-1];
            SRC_FAST: tick = tap[TAP_FAST-1];
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptmr_core.sv
`timescale 1ns/1ps
// ptmr_core: up-counter with period compare, interrupt pulse and live capture.
// Assumes ticks are never on consecutive clocks (smallest tap is 2 or more).
module ptmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] capture,
    output logic             irq
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             match;

    assign match   = (cnt == period);
    assign cnt_nxt = match ? '0 : cnt + 1'b1;

    // Hold at zero when stopped; step or wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_nxt;
    end

    // Raise a one-clock interrupt on a matching tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= run && tick && match;
    end

    // Copy the post-tick count while capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            capture <= '0;
        else if (run && tick && cap_en)
            capture <= cnt_nxt;
    end

    // R6
    match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt == period) |=> (irq && cnt == '0));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick && cap_en) |=> $stable(capture));

endmodule

// File: rtl/ptmr_top.sv
`timescale 1ns/1ps
// ptmr_top: prescaled interval timer with auto-capture.
// Assumes slow_tick is a synchronous one-clock pulse.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP_SLOW = 11,
    parameter int TAP_MID  = 7,
    parameter int TAP_FAST = 3,
    parameter int LS_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             slow_tick,
    input  logic             slow_mode,
    output logic [CNT_W-1:0] capture,
    output logic             irq
);

    localparam int DIV_W = TAP_SLOW;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic [DIV_W-1:0] tap;
    logic             slow_tap;
    logic             src_tick;

    ptmr_regs #(.DATA_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ctrl      (ctrl),
        .period    (period)
    );

    ptmr_prescaler #(.DIV_W(DIV_W), .LS_W(LS_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .slow_tick (slow_tick),
        .tap       (tap),
        .slow_tap  (slow_tap)
    );

    ptmr_tick_sel #(
        .DIV_W    (DIV_W),
        .TAP_SLOW (TAP_SLOW),
        .TAP_MID  (TAP_MID),
        .TAP_FAST (TAP_FAST)
    ) u_sel (
        .tap       (tap),
        .slow_tap  (slow_tap),
        .src       (ctrl.src),
        .divsel    (ctrl.divsel),
        .slow_mode (slow_mode),
        .tick      (src_tick)
    );

    ptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .tick    (src_tick),
        .cap_en  (ctrl.cap_en),
        .period  (period),
        .capture (capture),
        .irq     (irq)
    );

    // R5
    no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src == SRC_NONE) |=> ($stable(capture) && !irq));

endmodule

// File: tb/ptmr_top_test.sv
`timescale 1ns/1ps
// ptmr_top_test: cycle-stepped arithmetic model of the timer, compared every clock.
module ptmr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        slow_tick = 1'b0;
    logic        slow_mode = 1'b0;
    logic [15:0] capture;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string req = "R1";

    // model state
    int m_ctrl = 0, m_per = 0, m_cnt = 0, m_cap = 0, m_div = 0, m_ls = 0;
    logic m_irq = 1'b0;

    ptmr_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .slow_tick(slow_tick), .slow_mode(slow_mode),
        .capture(capture), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                summary();
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive, advance the model from pre-edge state, then compare.
    task automatic step(input logic wr, input logic [1:0] a, input int d, input logic st);
        logic run, cap, dsel, tk;
        int src, mask;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d[15:0]; slow_tick = st;
        @(posedge clk);
        run  = m_ctrl[0];
        src  = (m_ctrl >> 1) & 3;
        cap  = m_ctrl[3];
        dsel = m_ctrl[4];
        case (src)
            0: mask = 2047;
            1: mask = 127;
            2: mask = 7;
            default: mask = -1;
        endcase
        if (!run || mask < 0) tk = 1'b0;
        else if (src == 0 && (dsel || slow_mode)) tk = st && (m_ls == 7);
        else tk = ((m_div & mask) == mask);
        m_irq = 1'b0;
        if (!run) m_cnt = 0;
        else if (tk) begin
            if (m_cnt == m_per) begin m_cnt = 0; m_irq = 1'b1; end
            else m_cnt = (m_cnt + 1) & 65535;
            if (cap) m_cap = m_cnt;
        end
        m_div = run ? ((m_div + 1) & 2047) : 0;
        m_ls  = run ? (st ? ((m_ls + 1) & 7) : m_ls) : 0;
        if (wr && a == 2'd0) m_ctrl = d & 31;
        if (wr && a == 2'd1) m_per  = d & 65535;
        #1;
        check("irq", int'(irq), int'(m_irq));
        check("capture", int'(capture), m_cap);
    endtask

    task automatic idle(input int n, input int slow_every);
        for (int i = 0; i < n; i++)
            step(1'b0, 2'd0, 0, (slow_every > 0) && (i % slow_every == 0));
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        step(1'b1, a, d, 1'b0);
    endtask

    // control word: run | src<<1 | cap<<3 | divsel<<4
    function automatic int cw(input int run, input int src, input int cap, input int dsel);
        return run | (src << 1) | (cap << 3) | (dsel << 4);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        req = "R1";
        check("irq", int'(irq), 0);
        check("capture", int'(capture), 0);

        req = "R11";                       // addresses 2 and 3 ignored
        wr(2'd2, cw(1, 2, 1, 0));
        wr(2'd3, 16'hFFFF);
        idle(40, 0);

        req = "R10";                       // running without capture: capture stays 0
        wr(2'd1, 5);
        wr(2'd0, cw(1, 2, 0, 0));
        idle(60, 0);

        req = "R3";                        // fast tap, period 5
        wr(2'd0, 0);
        wr(2'd0, cw(1, 2, 1, 0));
        idle(400, 0);

        req = "R7";                        // period 0
        wr(2'd1, 0);
        idle(120, 0);

        req = "R8";                        // period change while running
        wr(2'd1, 20);
        idle(230, 0);
        wr(2'd1, 3);
        idle(200, 0);

        req = "R9";                        // mid tap, capture every tick
        wr(2'd0, 0);
        wr(2'd1, 2);
        wr(2'd0, cw(1, 1, 1, 0));
        idle(1600, 0);

        req = "R3";                        // slowest system tap
        wr(2'd0, 0);
        wr(2'd1, 1);
        wr(2'd0, cw(1, 0, 1, 0));
        idle(9000, 0);

        req = "R4";                        // divider select routes to slow pulses
        wr(2'd0, 0);
        wr(2'd1, 3);
        wr(2'd0, cw(1, 0, 1, 1));
        idle(1500, 3);

        req = "R4";                        // low-speed mode routes to slow pulses
        wr(2'd0, 0);
        slow_mode = 1'b1;
        wr(2'd0, cw(1, 0, 1, 0));
        idle(1200, 2);
        slow_mode = 1'b0;

        req = "R5";                        // reserved source code
        wr(2'd0, cw(1, 3, 1, 0));
        idle(400, 1);

        req = "R10";                       // capture disabled while running
        wr(2'd1, 9);
        wr(2'd0, cw(1, 2, 0, 0));
        idle(150, 0);
        req = "R10";                       // holds before first tick after enable
        wr(2'd0, cw(1, 2, 1, 0));
        idle(150, 0);

        req = "R2";                        // stop holds, restart counts from zero
        wr(2'd0, cw(0, 2, 1, 0));
        idle(50, 0);
        wr(2'd0, cw(1, 2, 1, 0));
        idle(200, 0);

        summary();
    end

endmodule